// File: doc/BRIEF.md
# Timeslot-Synchronous Transfer Interrupt Generator

This block follows a serial frame and tells a host processor when to move data for each of four channels. A frame sync restarts a bit counter that advances once every two data-clock cycles, and every eight bits make one timeslot. Each channel has a programmable transfer timeslot and a programmable check timeslot. A transfer flag is raised a short, mode-dependent number of bit clocks after the transfer timeslot ends. If the host has not acknowledged that transfer by a deadline tied to the check timeslot, an overflow flag is raised.

All eight flags sit in one status byte. Reading that byte clears every flag at once. A flag that is raised in the same cycle as the read survives the read. An interrupt line is asserted while any flag whose enable bit is set is active. Each channel's delay-mode bit selects a short or long offset for both its transfer flag and its overflow deadline.

Top module: `sts_irq_gen`

## Requirements
- R1: After reset, `status` is 0x00 and `irq` is 0.
- R2: `status` bits 7..4 are the overflow flags of channels 3..0 and bits 3..0 are the transfer flags of channels 3..0. A flag reads 1 when active. Channel c uses `sti_slot`/`chk_slot` bits [5c+4:5c].
- R3: With `dly_mode[c]`=0 and a frame sync sampled at clock edge k, transfer flag c reads 1 from edge k+2·P+1 on and 0 before it, where P = (8·(`sti_slot`+1)+2) mod 256.
- R4: With `dly_mode[c]`=1, the same rule holds with P = (8·(`sti_slot`+1)+1) mod 256.
- R5: With `dly_mode[c]`=0, an enabled overflow flag c is raised at edge k+2·Q+1, where Q = (8·`chk_slot`+255) mod 256, if a transfer of channel c is still unacknowledged at that point.
- R6: With `dly_mode[c]`=1, the overflow deadline is Q = 8·`chk_slot` mod 256.
- R7: A one-cycle `ack[c]` pulse after the transfer event and no later than the deadline cycle prevents overflow flag c. It leaves transfer flag c set.
- R8: An overflow whose `ovf_en[c]` bit is 0 is not recorded, so its status bit stays 0.
- R9: A `rd` pulse clears all status flags after that clock edge. Without `rd`, flags stay set.
- R10: A flag raised in the same cycle as `rd` reads 1 after the read.
- R11: `irq` is 1 exactly when some status flag is set together with its enable bit (`sti_en` for bits 3..0, `ovf_en` for bits 7..4).
- R12: A frame sync restarts the bit counter at bit 0. Each bit lasts two clock cycles, and the frame of 256 bits wraps on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, restarts the bit counter |
| sti_slot | input | 20 | Transfer timeslot per channel, 5 bits each |
| chk_slot | input | 20 | Overflow check timeslot per channel, 5 bits each |
| dly_mode | input | 4 | Delay-mode bit per channel (1 = short offsets) |
| ack | input | 4 | One-cycle acknowledge strobe per channel |
| sti_en | input | 4 | Transfer interrupt enables |
| ovf_en | input | 4 | Overflow interrupt enables; gates recording as well |
| rd | input | 1 | Status read strobe, clears flags |
| status | output | 8 | Flag byte: overflow 7..4, transfer 3..0 |
| irq | output | 1 | Masked OR of the flags |

## Verification
A wrong bit counter shifts every flag by whole cycles, so an off-by-one offset shows up as a transfer flag one cycle early or late against the exact edge k+2P+1. A lost or stuck pending state shows up only at the check timeslot, up to a frame later, as a missing or spurious overflow bit. For that reason the bench runs a per-cycle reference model alongside the directed edge checks. A mishandled read collision shows up in the cycle right after `rd` as a missing flag.

// File: rtl/sts_pkg.sv
package sts_pkg;

    typedef enum logic {
        DLY_LONG  = 1'b0,
        DLY_SHORT = 1'b1
    } dly_mode_e;

    // bit clocks after the end of the transfer timeslot
    function automatic logic [1:0] sti_offset(input logic mode);
        return (dly_mode_e'(mode) == DLY_SHORT) ? 2'd1 : 2'd2;
    endfunction

    // bit clocks ahead of the check timeslot start
    function automatic logic [1:0] chk_lead(input logic mode);
        return (dly_mode_e'(mode) == DLY_SHORT) ? 2'd0 : 2'd1;
    endfunction

endpackage

// File: rtl/sts_bitclock.sv
module sts_bitclock #(
    parameter int unsigned FRAME_BITS = 256,
    parameter int unsigned BIT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [BIT_W-1:0] bit_pos,
    output logic             half
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [BIT_W-1:0] pos;
        logic             half;
    } clk_state_t;

    clk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fsync) begin
            st_d.pos  = '0;
            st_d.half = 1'b0;
        end else if (!st_q.half) begin
            st_d.half = 1'b1;
        end else begin
            st_d.half = 1'b0;
            st_d.pos  = (st_q.pos == LAST_BIT) ? '0 : st_q.pos + BIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_pos = st_q.pos;
    assign half    = st_q.half;
endmodule

// File: rtl/sts_channel.sv
module sts_channel
    import sts_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS),
    parameter int unsigned BIT_W     = $clog2(SLOT_BITS * NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BIT_W-1:0]  bit_pos,
    input  logic              half,
    input  logic [SLOT_W-1:0] sti_slot,
    input  logic [SLOT_W-1:0] chk_slot,
    input  logic              dly,
    input  logic              ack,
    input  logic              ovf_en,
    output logic              sti_set,
    output logic              ovf_set
);
    localparam int unsigned FRAME = SLOT_BITS * NUM_SLOTS;
    localparam int unsigned EXT_W = BIT_W + 2;
    localparam logic [EXT_W-1:0] FRAME_X = EXT_W'(FRAME);
    localparam logic [EXT_W-1:0] SPAN_X  = EXT_W'(SLOT_BITS);
    localparam logic [EXT_W-1:0] ONE_X   = EXT_W'(1);

    typedef struct packed {
        logic pending;
    } ch_state_t;

    ch_state_t st_d, st_q;

    logic [EXT_W-1:0] sti_sum, chk_sum;
    logic [BIT_W-1:0] sti_pos, chk_pos;
    logic             sti_hit, chk_hit, late;

    function automatic logic [BIT_W-1:0] wrap(input logic [EXT_W-1:0] v);
        return (v >= FRAME_X) ? BIT_W'(v - FRAME_X) : BIT_W'(v);
    endfunction

    always_comb begin
        sti_sum = (EXT_W'(sti_slot) + ONE_X) * SPAN_X + EXT_W'(sti_offset(dly));
        chk_sum = EXT_W'(chk_slot) * SPAN_X + FRAME_X - EXT_W'(chk_lead(dly));
        sti_pos = wrap(sti_sum);
        chk_pos = wrap(chk_sum);
        sti_hit = !half && (bit_pos == sti_pos);
        chk_hit = !half && (bit_pos == chk_pos);
        late    = chk_hit && st_q.pending && !ack;

        st_d         = st_q;
        st_d.pending = sti_hit || (st_q.pending && !ack && !chk_hit);

        sti_set = sti_hit;
        ovf_set = late && ovf_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sts_flagreg.sv
module sts_flagreg #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd,
    input  logic [NUM_CH-1:0]   sti_set,
    input  logic [NUM_CH-1:0]   ovf_set,
    input  logic [NUM_CH-1:0]   sti_en,
    input  logic [NUM_CH-1:0]   ovf_en,
    output logic [2*NUM_CH-1:0] status,
    output logic                irq
);
    typedef struct packed {
        logic [NUM_CH-1:0] ovf;
        logic [NUM_CH-1:0] sti;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = rd ? '0 : st_q;
        st_d.ovf = st_d.ovf | ovf_set;
        st_d.sti = st_d.sti | sti_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q;
    assign irq    = |({st_q.ovf & ovf_en, st_q.sti & sti_en});
endmodule

// File: rtl/sts_irq_gen.sv
module sts_irq_gen #(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fsync,
    input  logic [NUM_CH*SLOT_W-1:0] sti_slot,
    input  logic [NUM_CH*SLOT_W-1:0] chk_slot,
    input  logic [NUM_CH-1:0]        dly_mode,
    input  logic [NUM_CH-1:0]        ack,
    input  logic [NUM_CH-1:0]        sti_en,
    input  logic [NUM_CH-1:0]        ovf_en,
    input  logic                     rd,
    output logic [2*NUM_CH-1:0]      status,
    output logic                     irq
);
    localparam int unsigned FRAME_BITS = SLOT_BITS * NUM_SLOTS;
    localparam int unsigned BIT_W      = $clog2(FRAME_BITS);

    logic [BIT_W-1:0]  bit_pos_w;
    logic              half_w;
    logic [NUM_CH-1:0] sti_set_w;
    logic [NUM_CH-1:0] ovf_set_w;

    sts_bitclock #(
        .FRAME_BITS (FRAME_BITS),
        .BIT_W      (BIT_W)
    ) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .bit_pos (bit_pos_w),
        .half    (half_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sts_channel #(
            .SLOT_BITS (SLOT_BITS),
            .NUM_SLOTS (NUM_SLOTS),
            .SLOT_W    (SLOT_W),
            .BIT_W     (BIT_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .bit_pos  (bit_pos_w),
            .half     (half_w),
            .sti_slot (sti_slot[c*SLOT_W +: SLOT_W]),
            .chk_slot (chk_slot[c*SLOT_W +: SLOT_W]),
            .dly      (dly_mode[c]),
            .ack      (ack[c]),
            .ovf_en   (ovf_en[c]),
            .sti_set  (sti_set_w[c]),
            .ovf_set  (ovf_set_w[c])
        );
    end

    sts_flagreg #(
        .NUM_CH (NUM_CH)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (rd),
        .sti_set (sti_set_w),
        .ovf_set (ovf_set_w),
        .sti_en  (sti_en),
        .ovf_en  (ovf_en),
        .status  (status),
        .irq     (irq)
    );
endmodule

// File: rtl/sts_irq_gen_chk.sv
module sts_irq_gen_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned BIT_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fsync,
    input logic                rd,
    input logic [NUM_CH-1:0]   ack,
    input logic [NUM_CH-1:0]   ovf_en,
    input logic [2*NUM_CH-1:0] status,
    input logic                irq,
    input logic [NUM_CH-1:0]   sti_set,
    input logic [NUM_CH-1:0]   ovf_set,
    input logic [BIT_W-1:0]    bit_pos,
    input logic                half
);
    logic [2*NUM_CH-1:0] set_vec;
    assign set_vec = {ovf_set, sti_set};

    assert_fsync_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (bit_pos == '0 && !half));

    assert_bit_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync && !half) |=> (half && bit_pos == $past(bit_pos)));

    assert_sti_first_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sti_set != '0) |-> !half);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_set & ~ovf_en) == '0);

    assert_ack_in_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_set & ack) == '0);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> ((status & ~$past(set_vec)) == '0));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((status & $past(status)) == $past(status)));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

    assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

bind sts_irq_gen sts_irq_gen_chk #(
    .NUM_CH (NUM_CH),
    .BIT_W  (BIT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fsync   (fsync),
    .rd      (rd),
    .ack     (ack),
    .ovf_en  (ovf_en),
    .status  (status),
    .irq     (irq),
    .sti_set (sti_set_w),
    .ovf_set (ovf_set_w),
    .bit_pos (bit_pos_w),
    .half    (half_w)
);

// File: tb/sts_irq_gen_tb.sv
module sts_irq_gen_tb;
    localparam int FRAME = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic [19:0] sti_slot = '0;
    logic [19:0] chk_slot = '0;
    logic [3:0]  dly_mode = '0;
    logic [3:0]  ack = '0;
    logic [3:0]  sti_en = '0;
    logic [3:0]  ovf_en = '0;
    logic        rd = 1'b0;
    logic [7:0]  status;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int off    = 0;
    int wd     = 0;
    int unsigned seed_tmp;

    always #5 clk = ~clk;

    sts_irq_gen u_dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .sti_slot(sti_slot),
        .chk_slot(chk_slot), .dly_mode(dly_mode), .ack(ack), .sti_en(sti_en),
        .ovf_en(ovf_en), .rd(rd), .status(status), .irq(irq)
    );

    function automatic int sti_bit(input logic [4:0] s, input logic m);
        return (8 * (int'(s) + 1) + (m ? 1 : 2)) % FRAME;
    endfunction

    function automatic int chk_bit(input logic [4:0] s, input logic m);
        return (8 * int'(s) + FRAME - (m ? 0 : 1)) % FRAME;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at offset %0d", tag, act, exp, off);
        end
    endtask

    // reference model, updated on inputs seen at each edge
    int         m_cnt;
    logic [3:0] m_pend;
    logic [7:0] m_stat;
    logic [7:0] m_set;
    logic [3:0] m_np;
    logic       m_sev, m_cev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_pend = '0; m_stat = '0;
        end else begin
            m_set = '0;
            m_np  = m_pend;
            for (int c = 0; c < 4; c++) begin
                m_sev = (m_cnt % 2 == 0) && (m_cnt / 2 == sti_bit(sti_slot[c*5 +: 5], dly_mode[c]));
                m_cev = (m_cnt % 2 == 0) && (m_cnt / 2 == chk_bit(chk_slot[c*5 +: 5], dly_mode[c]));
                if (m_cev && m_pend[c] && !ack[c] && ovf_en[c]) m_set[4+c] = 1'b1;
                if (m_sev) m_set[c] = 1'b1;
                m_np[c] = m_sev || (m_pend[c] && !ack[c] && !m_cev);
            end
            m_stat = (rd ? 8'h00 : m_stat) | m_set;
            m_pend = m_np;
            m_cnt  = fsync ? 0 : (m_cnt + 1) % (2 * FRAME);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            #2;
            check("R2 model status", status, m_stat);
            check("R11 model irq", {7'd0, irq}, {7'd0, |(m_stat & {ovf_en, sti_en})});
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd == 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic goto(input int n);
        while (off < n) begin
            @(negedge clk);
            off++;
        end
        #1;
    endtask

    task automatic frame_sync();
        @(negedge clk);
        #1 fsync = 1'b1;
        @(negedge clk);
        #1 fsync = 1'b0;
        off = 0;
    endtask

    initial begin
        seed_tmp = $urandom(32'd7321);
        sti_slot = {5'd9, 5'd8, 5'd5, 5'd3};
        chk_slot = {5'd16, 5'd14, 5'd12, 5'd10};
        dly_mode = 4'b1010;
        ovf_en   = 4'b0111;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset status", status, 8'h00);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;

        frame_sync();
        goto(68);  check("R3 long sti early", {7'd0, status[0]}, 8'h00);
        goto(69);  check("R3 long sti on time", {7'd0, status[0]}, 8'h01);
        goto(70);  check("R11 masked irq", {7'd0, irq}, 8'h00);
        sti_en = 4'b0001;
        goto(72);  check("R11 enabled irq", {7'd0, irq}, 8'h01);
        goto(98);  check("R4 short sti early", {7'd0, status[1]}, 8'h00);
        goto(99);  check("R4 short sti on time", {7'd0, status[1]}, 8'h01);
        goto(158); check("R5 long ovf early", {7'd0, status[4]}, 8'h00);
        goto(159); check("R5 long ovf on time", {7'd0, status[4]}, 8'h01);
        check("R2 full byte", status, 8'h17);
        goto(160); ack = 4'b0100;
        goto(161); ack = 4'b0000;
        goto(192); check("R6 short ovf early", {7'd0, status[5]}, 8'h00);
        goto(193); check("R6 short ovf on time", {7'd0, status[5]}, 8'h01);
        goto(230); check("R7 acked no ovf", {7'd0, status[6]}, 8'h00);
        check("R7 sti kept", {7'd0, status[2]}, 8'h01);
        sti_en = 4'b0000;
        check("R11 ovf irq", {7'd0, irq}, 8'h01);
        goto(260); check("R8 disabled ovf", {7'd0, status[7]}, 8'h00);
        check("R8 sti recorded", {7'd0, status[3]}, 8'h01);
        goto(262); rd = 1'b1;
        goto(263); rd = 1'b0;
        check("R9 read clears", status, 8'h00);
        goto(400); check("R9 stays clear", status, 8'h00);
        goto(580); rd = 1'b1;
        goto(581); rd = 1'b0;
        check("R10 set wins read", status, 8'h01);
        goto(590); rd = 1'b1;
        goto(591); rd = 1'b0;
        goto(600);
        frame_sync();
        goto(68);  check("R12 restart early", {7'd0, status[0]}, 8'h00);
        goto(69);  check("R12 restart on time", {7'd0, status[0]}, 8'h01);

        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            #1;
            fsync = ($urandom % 900) == 0;
            rd    = ($urandom % 50) == 0;
            for (int c = 0; c < 4; c++) ack[c] = ($urandom % 40) == 0;
            if (($urandom % 400) == 0) begin
                sti_slot = 20'($urandom);
                chk_slot = 20'($urandom);
                dly_mode = 4'($urandom);
                sti_en   = 4'($urandom);
                ovf_en   = 4'($urandom);
            end
        end
        @(negedge clk);
        #1 fsync = 1'b0; rd = 1'b0; ack = '0;
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule